// File: doc/BRIEF.md
# SPI Controller Frame Engine with Parity

This block is the controller half of an SPI port. A single write of a transmit word launches one frame: the engine pulls chip select low, produces the serial clock from a programmable divide of the system clock, shifts the data bits out on the output line and captures the same number of bits from the input line. The number of data bits is programmable from 4 to 16. Data can be sent most- or least-significant bit first, and the same order applies to the received word.

An optional parity bit follows the data bits. It is added when either transmit or receive parity is enabled. One select bit chooses even or odd sense for both directions. A received word is offered on a one-cycle valid strobe once the whole frame has completed. A parity-error pulse goes with it when the received parity does not match. The clock idles at a selectable polarity. Data is sampled on the leading clock edge and changed on the trailing one. While a frame runs, the block reports busy and ignores further start strobes.

Top module: `spi_frame_engine`

## Requirements
- R1: After reset and between frames, csN is 1, busy is 0, rxValid is 0 and sclk equals cfgCpol.
- R2: A txWrite seen while idle makes csN 0 and busy 1 from the next cycle. Each sclk half period lasts cfgDiv+1 clock cycles. busy stays high for exactly 2*(cfgDiv+1)*N cycles, where N is cfgLen plus one if cfgTxParEn or cfgRxParEn is 1.
- R3: cfgLen gives the data bit count, legal from 4 to 16. Only txData bits below cfgLen are sent, and exactly N leading sclk edges occur per frame.
- R4: When txByteWrite is 1 with txWrite, only txData[7:0] is used and frame bits 8 and above are sent as 0.
- R5: cfgLsbFirst=0 sends data bit cfgLen-1 first and cfgLsbFirst=1 sends bit 0 first. The k-th received bit goes to the same bit position, and rxData bits at cfgLen and above read 0.
- R6: With cfgTxParEn=1, the bit after the data is the XOR of the sent data bits XOR cfgParOdd. If only cfgRxParEn is 1, mosi is 0 in that slot.
- R7: With cfgRxParEn=1, parErr pulses together with rxValid when the XOR of the received data bits and the received parity bit differs from cfgParOdd. parErr stays 0 whenever cfgRxParEn is 0.
- R8: rxValid is a one-cycle pulse. It rises in the cycle in which busy falls, and rxData holds the captured word.
- R9: A txWrite while busy is ignored: the running frame's length, sent bits and received word do not change, and no extra frame starts.
- R10: sclk moves away from cfgCpol on a leading edge and back on a trailing edge. miso is sampled on leading edges, and mosi changes only at trailing edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLen | input | 5 | Data bits per frame, 4 to 16 |
| cfgLsbFirst | input | 1 | 1: least significant bit first |
| cfgCpol | input | 1 | Idle level of sclk |
| cfgDiv | input | 8 | sclk half period minus one, in clock cycles |
| cfgTxParEn | input | 1 | Append a parity bit on transmit |
| cfgRxParEn | input | 1 | Check a parity bit on receive |
| cfgParOdd | input | 1 | 1: odd parity, 0: even parity |
| txWrite | input | 1 | Start strobe with transmit word |
| txByteWrite | input | 1 | Qualifies txWrite as an 8-bit write |
| txData | input | 16 | Transmit word |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| busy | output | 1 | Frame in progress |
| rxValid | output | 1 | Received word strobe |
| rxData | output | 16 | Received word |
| parErr | output | 1 | Parity mismatch on the word strobed |

## Verification
A wrong bit counter or a wrong latched length shows as a wrong number of leading sclk edges and a busy window of the wrong length. Both are visible by the end of the frame. A wrong bit index shows as a mis-ordered mosi stream within the first few bit times, and later as a permuted rxData. A wrong parity state shows in the parity slot on mosi, or as a wrong parErr on the rxValid strobe. A stray start accepted while busy shows as a changed mosi stream or as a second chip-select window.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef struct packed {
    logic load;    // frame start accepted
    logic sample;  // leading edge: capture miso
    logic shift;   // trailing edge, more bits follow
    logic finish;  // trailing edge of the final bit
  } engStrobe_t;
endpackage

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txWrite,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic [CNT_W-1:0] frameBitsIn,
  output engStrobe_t       strb,
  output logic             busy,
  output logic             half
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLat;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] nBits;
  logic tick;
  logic lastBit;

  assign tick    = busy && (divCnt == divLat);
  assign lastBit = (bitCnt == nBits - CNT_W'(1));

  always_comb begin
    strb.load   = !busy && txWrite;
    strb.sample = tick && !half;
    strb.shift  = tick && half && !lastBit;
    strb.finish = tick && half && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      half   <= 1'b0;
      divCnt <= '0;
      divLat <= '0;
      bitCnt <= '0;
      nBits  <= '0;
    end else if (!busy) begin
      divCnt <= '0;
      half   <= 1'b0;
      bitCnt <= '0;
      if (txWrite) begin
        busy   <= 1'b1;
        nBits  <= frameBitsIn;
        divLat <= cfgDiv;
      end
    end else if (tick) begin
      divCnt <= '0;
      if (!half) begin
        half <= 1'b1;
      end else begin
        half <= 1'b0;
        if (lastBit) busy <= 1'b0;
        else bitCnt <= bitCnt + CNT_W'(1);
      end
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // R9: a start strobe during a frame changes neither the frame nor its length
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && txWrite && !strb.finish) |=> (busy && $stable(nBits)));

  // R2: the bit counter never passes the latched frame length
  assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitCnt < nBits));

  // R2: a frame only begins after a start strobe
  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(txWrite));
endmodule

// File: rtl/spi_eng_dp.sv
module spi_eng_dp
  import spi_eng_pkg::*;
#(
  parameter int MAX_W = 16,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  engStrobe_t       strb,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             cfgLsbFirst,
  input  logic             cfgTxParEn,
  input  logic             cfgRxParEn,
  input  logic             cfgParOdd,
  input  logic             txByteWrite,
  input  logic [MAX_W-1:0] txData,
  input  logic             miso,
  output logic             mosi,
  output logic [MAX_W-1:0] rxData,
  output logic             rxValid,
  output logic             parErr
);
  localparam int IDX_W = $clog2(MAX_W);

  logic [MAX_W-1:0] txWord, rxWord;
  logic [MAX_W-1:0] lenMask, byteMask;
  logic [LEN_W-1:0] bitIdx, lenLat, posWide;
  logic [IDX_W-1:0] pos;
  logic lsbLat, tpLat, rpLat, oddLat, parRx, active;
  logic inParity;

  assign lenMask  = ~({MAX_W{1'b1}} << cfgLen);
  assign byteMask = {{(MAX_W-8){1'b0}}, {8{1'b1}}};
  assign inParity = (bitIdx >= lenLat);
  assign posWide  = lsbLat ? bitIdx : (lenLat - LEN_W'(1) - bitIdx);
  assign pos      = IDX_W'(posWide);

  always_comb begin
    if (!active) mosi = 1'b0;
    else if (inParity) mosi = tpLat & ((^txWord) ^ oddLat);
    else mosi = txWord[pos];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWord  <= '0;
      rxWord  <= '0;
      bitIdx  <= '0;
      lenLat  <= '0;
      lsbLat  <= 1'b0;
      tpLat   <= 1'b0;
      rpLat   <= 1'b0;
      oddLat  <= 1'b0;
      parRx   <= 1'b0;
      active  <= 1'b0;
      rxData  <= '0;
      rxValid <= 1'b0;
      parErr  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      parErr  <= 1'b0;
      if (strb.load) begin
        txWord <= txData & lenMask & (txByteWrite ? byteMask : {MAX_W{1'b1}});
        rxWord <= '0;
        bitIdx <= '0;
        lenLat <= cfgLen;
        lsbLat <= cfgLsbFirst;
        tpLat  <= cfgTxParEn;
        rpLat  <= cfgRxParEn;
        oddLat <= cfgParOdd;
        parRx  <= 1'b0;
        active <= 1'b1;
      end
      if (strb.sample) begin
        if (inParity) parRx <= miso;
        else rxWord[pos] <= miso;
      end
      if (strb.shift) bitIdx <= bitIdx + LEN_W'(1);
      if (strb.finish) begin
        active  <= 1'b0;
        rxValid <= 1'b1;
        rxData  <= rxWord;
        parErr  <= rpLat & (((^rxWord) ^ parRx) != oddLat);
      end
    end
  end

  // R8: the received-word strobe lasts one cycle
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R7: a parity error only accompanies a word received with checking on
  assert_parerr_qualified_R7: assert property (@(posedge clk) disable iff (!rstN)
    parErr |-> (rxValid && rpLat));

  // R3: a frame is only started with a legal length
  assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> (cfgLen >= LEN_W'(4) && cfgLen <= LEN_W'(MAX_W)));
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_eng_pkg::*;
#(
  parameter int MAX_W = 16,
  parameter int DIV_W = 8,
  parameter int LEN_W = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             cfgLsbFirst,
  input  logic             cfgCpol,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             cfgTxParEn,
  input  logic             cfgRxParEn,
  input  logic             cfgParOdd,
  input  logic             txWrite,
  input  logic             txByteWrite,
  input  logic [MAX_W-1:0] txData,
  input  logic             miso,
  output logic             sclk,
  output logic             csN,
  output logic             mosi,
  output logic             busy,
  output logic             rxValid,
  output logic [MAX_W-1:0] rxData,
  output logic             parErr
);
  engStrobe_t       strb;
  logic             half;
  logic [LEN_W-1:0] frameBitsIn;

  assign frameBitsIn = cfgLen + LEN_W'(cfgTxParEn | cfgRxParEn);
  assign sclk = cfgCpol ^ half;
  assign csN  = !busy;

  spi_eng_ctrl #(.DIV_W(DIV_W), .CNT_W(LEN_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .txWrite(txWrite), .cfgDiv(cfgDiv),
    .frameBitsIn(frameBitsIn), .strb(strb), .busy(busy), .half(half)
  );

  spi_eng_dp #(.MAX_W(MAX_W), .LEN_W(LEN_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgLen(cfgLen),
    .cfgLsbFirst(cfgLsbFirst), .cfgTxParEn(cfgTxParEn),
    .cfgRxParEn(cfgRxParEn), .cfgParOdd(cfgParOdd),
    .txByteWrite(txByteWrite), .txData(txData), .miso(miso),
    .mosi(mosi), .rxData(rxData), .rxValid(rxValid), .parErr(parErr)
  );

  // R10: with chip select released the clock rests at its idle level
  assert_sclk_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (sclk == cfgCpol));

  // R10: mosi only moves while sclk is at its idle level (trailing edges)
  assert_mosi_trailing_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN) && !$stable(mosi)) |-> (sclk == cfgCpol));
endmodule

// File: tb/test_spi_frame_engine.sv
module test_spi_frame_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] cfgLen = 5'd8;
  logic cfgLsbFirst = 1'b0, cfgCpol = 1'b0;
  logic [7:0] cfgDiv = 8'd1;
  logic cfgTxParEn = 1'b0, cfgRxParEn = 1'b0, cfgParOdd = 1'b0;
  logic txWrite = 1'b0, txByteWrite = 1'b0;
  logic [15:0] txData = '0;
  logic miso = 1'b0;
  logic sclk, csN, mosi, busy, rxValid, parErr;
  logic [15:0] rxData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int nBits;
    logic [16:0] mosiSeq;
    logic [15:0] rxExp;
    logic perExp;
  } expItem_t;
  expItem_t expQ[$];

  logic [16:0] misoSeq = '0;
  logic [16:0] capMosi = '0;
  int sIdx = 0;
  int capCnt = 0;

  always #4 clk = ~clk;  // 125 MHz

  spi_frame_engine i_spi_frame_engine (
    .clk(clk), .rstN(rstN), .cfgLen(cfgLen), .cfgLsbFirst(cfgLsbFirst),
    .cfgCpol(cfgCpol), .cfgDiv(cfgDiv), .cfgTxParEn(cfgTxParEn),
    .cfgRxParEn(cfgRxParEn), .cfgParOdd(cfgParOdd), .txWrite(txWrite),
    .txByteWrite(txByteWrite), .txData(txData), .miso(miso), .sclk(sclk),
    .csN(csN), .mosi(mosi), .busy(busy), .rxValid(rxValid), .rxData(rxData),
    .parErr(parErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Peripheral model: drives miso, captures mosi on leading edges
  always @(negedge csN) begin
    sIdx = 0;
    capCnt = 0;
    capMosi = '0;
    miso = misoSeq[0];
  end

  always @(sclk) begin
    if (!csN) begin
      if (sclk != cfgCpol) begin
        if (capCnt < 17) capMosi[capCnt] = mosi;
        capCnt++;
      end else begin
        sIdx++;
        if (sIdx < 17) miso = misoSeq[sIdx];
      end
    end
  end

  // Monitor: pops the scoreboard on each received word
  always @(negedge clk) begin
    if (rxValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9", "unexpected rxValid", 32'd1, 32'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(capCnt == e.nBits, "R3", "leading edge count", capCnt, e.nBits);
        check(capMosi == e.mosiSeq, "R5/R6", "mosi bit stream", capMosi, e.mosiSeq);
        check(rxData == e.rxExp, "R5", "rxData", rxData, e.rxExp);
        check(parErr == e.perExp, "R7", "parErr", parErr, e.perExp);
        check(busy == 1'b0, "R8", "busy low with rxValid", busy, 0);
      end
    end
  end

  task automatic runFrame(input int len, input bit lsb, input bit tp, input bit rp,
                          input bit odd, input int div, input bit cpol, input bit byteW,
                          input logic [15:0] data, input logic [15:0] mData,
                          input bit wantErr, input bit pokeBusy);
    expItem_t e;
    logic [15:0] mask, dm, md;
    int cycles;
    @(negedge clk);
    cfgLen = 5'(len); cfgLsbFirst = lsb; cfgTxParEn = tp; cfgRxParEn = rp;
    cfgParOdd = odd; cfgDiv = 8'(div); cfgCpol = cpol;
    mask = (len == 16) ? 16'hFFFF : ((16'h1 << len) - 16'h1);
    dm = data & mask & (byteW ? 16'h00FF : 16'hFFFF);
    md = mData & mask;
    e.nBits = len + ((tp || rp) ? 1 : 0);
    e.mosiSeq = '0;
    misoSeq = '0;
    for (int i = 0; i < len; i++) begin
      e.mosiSeq[i] = lsb ? dm[i] : dm[len-1-i];
      misoSeq[i]   = lsb ? md[i] : md[len-1-i];
    end
    if (tp || rp) begin
      e.mosiSeq[len] = tp ? ((^dm) ^ odd) : 1'b0;
      misoSeq[len] = (^md) ^ odd ^ wantErr;
    end
    e.rxExp = md;
    e.perExp = rp && wantErr;
    expQ.push_back(e);
    @(negedge clk);
    check(sclk == cpol, "R1", "idle sclk level", sclk, cpol);
    txWrite = 1'b1; txByteWrite = byteW; txData = data;
    @(negedge clk);
    txWrite = 1'b0; txByteWrite = 1'b0;
    check(busy && !csN, "R2", "frame start busy/csN", {busy, csN}, 2'b10);
    cycles = 0;
    while (busy) begin
      cycles++;
      if (pokeBusy && cycles == 3) begin
        txWrite = 1'b1; txData = ~data;
      end else begin
        txWrite = 1'b0;
      end
      @(negedge clk);
    end
    txWrite = 1'b0;
    check(cycles == 2 * (div + 1) * e.nBits, "R2", "busy duration", cycles,
          2 * (div + 1) * e.nBits);
    check(csN == 1'b1 && sclk == cpol, "R1", "idle after frame", {csN, sclk}, {1'b1, cpol});
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R8", "word delivered", expQ.size(), 0);
    if (pokeBusy) check(busy == 1'b0, "R9", "no extra frame", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(csN && !busy && !rxValid && sclk == 1'b0, "R1", "reset state",
          {csN, busy, rxValid, sclk}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    // len, lsb, tp, rp, odd, div, cpol, byteW, data, mData, wantErr, poke
    runFrame(8, 0, 0, 0, 0, 1, 0, 0, 16'h00A5, 16'h003C, 0, 0);   // R3 R5 msb
    runFrame(8, 1, 0, 0, 0, 1, 0, 0, 16'h001E, 16'h0047, 0, 0);   // R5 lsb
    runFrame(16, 0, 1, 1, 0, 0, 0, 0, 16'hBEEF, 16'h1234, 0, 0);  // R6 R7 even
    runFrame(4, 1, 1, 1, 1, 0, 1, 0, 16'hFFFB, 16'hFFF6, 1, 0);   // R3 R7 odd error, cpol1
    runFrame(12, 0, 0, 1, 1, 2, 0, 1, 16'hABCD, 16'h0F0F, 0, 0);  // R4 R6 rx-only parity
    runFrame(7, 0, 0, 0, 0, 2, 0, 0, 16'h0055, 16'h002A, 0, 1);   // R9 start while busy
    runFrame(16, 1, 1, 0, 1, 3, 1, 0, 16'h8001, 16'hC3A5, 1, 0);  // R6 tx-only, R7 no flag
    runFrame(9, 0, 1, 1, 0, 1, 0, 0, 16'h01FF, 16'h0155, 1, 1);   // R7 even error, R9
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule